// File: doc/BRIEF.md
# Six-Stage Pipeline Interlock Controller

This block decides, each cycle, which stages of a six-stage in-order pipeline hold their contents and which load an empty slot. The stages are indexed 0 to 5: 0 = PC generation (PG), 1 = fetch (IF), 2 = decode (ID), 3 = execute (EX), 4 = memory (MEM), 5 = writeback (WB). Bit `i` of every six-bit vector on the ports refers to stage `i`. It also owns the program counter register that feeds PC generation.

There are no operand forwarding paths. A decode instruction that reads a register still being produced by a valid, writing instruction in EX, MEM or WB is held until that producer has left writeback. A busy instruction port holds fetch and PC generation. A busy data port holds memory and everything before it. A branch mispredict reported by a valid execute instruction discards the instructions in PG, IF and ID and loads the redirect target into the PC. When a stage holds and the stage after it does not, an empty slot (valid cleared) goes into the stage after it.

All pins are plain control levels sampled on the rising clock edge. Nothing here is a stream, so there is no valid/ready handshake and no back-pressure beyond the stall vector itself. `stage_stall[i]`=1 means the register of stage `i` keeps its contents. `stage_flush[i]`=1 means it loads an empty slot on the next edge. The outputs are combinational from the inputs, except `pc`, which is registered.

Top module: `pipe_interlock`

## Requirements
- R1: While `rst_n` is low, `stage_flush` is 6'b111111, `stage_stall` is 0 and `pc` equals parameter `RESET_PC`. After release, `pc` starts from `RESET_PC`.
- R2: Take a valid ID instruction (bit 2) with a nonzero `id_rs1` or `id_rs2` equal to the `rd` of a valid (bits 3/4/5) writing (`*_rd_we`=1) EX, MEM or WB instruction. Then stall bits 0..2 are 1, and flush bit 3 equals the inverse of stall bit 3.
- R3: Register index 0 never causes a hold, even when it is a written destination.
- R4: With no hazard, no busy port and no mispredict, `stage_stall` and `stage_flush` are 0, and `pc` rises by 4 on every edge.
- R5: `imem_busy` with fetch valid sets stall bits 0..1. Flush bit 2 is set unless ID is held.
- R6: `dmem_busy` with memory valid sets stall bits 0..4 and flush bit 5.
- R7: `mispredict` with EX valid sets flush bits 1 and 2 and clears stall bits 0..2. On the next edge `pc` equals `redirect_pc`.
- R8: A mispredict wins over any hold of stages 0..2 in the same cycle: a data-port hold then keeps only stall bits 3..4, and no stage ever has stall and flush both set.
- R9: `stage_stall[5]` is always 0. `pc` keeps its value across an edge where stall bit 0 is set and no redirect occurs.
- R10: A mispredict with EX invalid, and a match against an invalid or non-writing producer, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| stage_valid | input | 6 | Valid bit of each stage |
| id_rs1 | input | REG_W | First source register of the decode instruction |
| id_rs2 | input | REG_W | Second source register of the decode instruction |
| ex_rd | input | REG_W | Destination of the execute instruction |
| ex_rd_we | input | 1 | Execute instruction writes `ex_rd` |
| mem_rd | input | REG_W | Destination of the memory-stage instruction |
| mem_rd_we | input | 1 | Memory-stage instruction writes `mem_rd` |
| wb_rd | input | REG_W | Destination of the writeback instruction |
| wb_rd_we | input | 1 | Writeback instruction writes `wb_rd` |
| imem_busy | input | 1 | Instruction port has a transaction outstanding |
| dmem_busy | input | 1 | Data port has a transaction outstanding |
| mispredict | input | 1 | Execute instruction found the wrong path was fetched |
| redirect_pc | input | XLEN | Correct next PC on a mispredict |
| stage_stall | output | 6 | Hold the contents of each stage |
| stage_flush | output | 6 | Load an empty slot into each stage |
| pc | output | XLEN | Current PC generation value |

## Verification
The interesting overlap is a mispredict in the same cycle as a hold. The hold may come from a decode hazard, a busy instruction port, or a busy data port that keeps execute itself in place. The vector table drives these pairs together with all stages valid and compares both six-bit vectors against values derived from R7 and R8. A data-port hold plus a mispredict must show stall only on bits 3..4 and flush on bits 1, 2 and 5. Directed tests then confirm that `pc` takes the redirect target even when decode was asking to hold.

// File: rtl/pipe_ctl_pkg.sv
package pipe_ctl_pkg;
  localparam int NSTAGE = 6;
  localparam int ST_PG  = 0;
  localparam int ST_IF  = 1;
  localparam int ST_ID  = 2;
  localparam int ST_EX  = 3;
  localparam int ST_MEM = 4;
  localparam int ST_WB  = 5;
  // producers checked against decode: EX, MEM, WB
  localparam int NPROD  = NSTAGE - ST_EX;
  typedef logic [NSTAGE-1:0] stage_vec_t;
endpackage

// File: rtl/pipe_raw_detect.sv
module pipe_raw_detect #(
  parameter int REG_W = 5,
  parameter int NPROD = 3
) (
  input  logic [REG_W-1:0]            rs1,
  input  logic [REG_W-1:0]            rs2,
  input  logic [NPROD-1:0]            prod_valid,
  input  logic [NPROD-1:0]            prod_we,
  input  logic [NPROD-1:0][REG_W-1:0] prod_rd,
  output logic                        hazard
);
  logic [NPROD-1:0] hit;

  for (genvar p = 0; p < NPROD; p++) begin : g_prod
    logic live;
    assign live   = prod_valid[p] && prod_we[p] && (prod_rd[p] != '0);
    assign hit[p] = live && ((prod_rd[p] == rs1) || (prod_rd[p] == rs2));
  end

  assign hazard = |hit;
endmodule

// File: rtl/pipe_stall_chain.sv
module pipe_stall_chain #(
  parameter int NSTAGE = 6
) (
  input  logic [NSTAGE-1:0] hold_req,
  input  logic [NSTAGE-1:0] kill,
  output logic [NSTAGE-1:0] stall,
  output logic [NSTAGE-1:0] flush
);
  // a hold request at stage i freezes stage i and all younger ones
  logic [NSTAGE:0] below;
  assign below[NSTAGE] = 1'b0;

  for (genvar i = NSTAGE - 1; i >= 0; i--) begin : g_hold
    assign below[i] = below[i+1] | hold_req[i];
    assign stall[i] = below[i] & ~kill[i];
  end

  assign flush[0] = 1'b0;
  for (genvar i = 1; i < NSTAGE; i++) begin : g_bubble
    assign flush[i] = (kill[i-1] | stall[i-1]) & ~stall[i];
  end
endmodule

// File: rtl/pipe_pc_gen.sv
module pipe_pc_gen #(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            redirect,
  input  logic [XLEN-1:0] target,
  output logic [XLEN-1:0] pc
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);
  logic [XLEN-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc_q <= RESET_PC;
    else if (redirect) pc_q <= target;
    else if (advance)  pc_q <= pc_q + STEP;
  end

  assign pc = pc_q;
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import pipe_ctl_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              REG_W    = 5,
  parameter logic [XLEN-1:0] RESET_PC = 32'h0000_0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       stage_valid,
  input  logic [REG_W-1:0] id_rs1,
  input  logic [REG_W-1:0] id_rs2,
  input  logic [REG_W-1:0] ex_rd,
  input  logic             ex_rd_we,
  input  logic [REG_W-1:0] mem_rd,
  input  logic             mem_rd_we,
  input  logic [REG_W-1:0] wb_rd,
  input  logic             wb_rd_we,
  input  logic             imem_busy,
  input  logic             dmem_busy,
  input  logic             mispredict,
  input  logic [XLEN-1:0]  redirect_pc,
  output logic [5:0]       stage_stall,
  output logic [5:0]       stage_flush,
  output logic [XLEN-1:0]  pc
);
  logic                        raw_hit;
  logic                        redirect;
  stage_vec_t                  raw_req, hold_req, kill, stall_c, flush_c;
  logic [NPROD-1:0][REG_W-1:0] prod_rd;

  assign prod_rd = {wb_rd, mem_rd, ex_rd};

  pipe_raw_detect #(.REG_W(REG_W), .NPROD(NPROD)) u_raw (
    .rs1        (id_rs1),
    .rs2        (id_rs2),
    .prod_valid (stage_valid[ST_WB:ST_EX]),
    .prod_we    ({wb_rd_we, mem_rd_we, ex_rd_we}),
    .prod_rd    (prod_rd),
    .hazard     (raw_hit)
  );

  // each hold source counts only when its own stage holds an instruction
  always_comb begin
    raw_req         = '0;
    raw_req[ST_IF]  = imem_busy;
    raw_req[ST_ID]  = raw_hit;
    raw_req[ST_MEM] = dmem_busy;
    hold_req        = raw_req & stage_valid;
  end

  assign redirect = mispredict & stage_valid[ST_EX];

  for (genvar i = 0; i < NSTAGE; i++) begin : g_kill
    assign kill[i] = redirect && (i < ST_EX);
  end

  pipe_stall_chain #(.NSTAGE(NSTAGE)) u_chain (
    .hold_req (hold_req),
    .kill     (kill),
    .stall    (stall_c),
    .flush    (flush_c)
  );

  pipe_pc_gen #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (~stall_c[ST_PG]),
    .redirect (redirect),
    .target   (redirect_pc),
    .pc       (pc)
  );

  assign stage_stall = rst_n ? stall_c : '0;
  assign stage_flush = rst_n ? flush_c : '1;
endmodule

// File: rtl/pipe_interlock_chk.sv
module pipe_interlock_chk #(
  parameter int XLEN  = 32,
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [5:0]       stage_valid,
  input logic [REG_W-1:0] id_rs1,
  input logic [REG_W-1:0] id_rs2,
  input logic             imem_busy,
  input logic             dmem_busy,
  input logic             mispredict,
  input logic [XLEN-1:0]  redirect_pc,
  input logic [5:0]       stage_stall,
  input logic [5:0]       stage_flush,
  input logic [XLEN-1:0]  pc
);
  logic redir;
  assign redir = mispredict && stage_valid[3];

  AST_RESET_FLUSH: assert property (@(posedge clk)
    !rst_n |-> (stage_flush == 6'h3f && stage_stall == 6'h00)); // R1

  AST_RAW_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_stall[2] && !stage_stall[3]) |-> stage_flush[3]); // R2

  AST_X0_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rs1 == '0 && id_rs2 == '0 && !imem_busy && !dmem_busy) |-> stage_stall == 6'h00); // R3

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stage_stall[0] && !redir) |=> pc == $past(pc) + XLEN'(4)); // R4

  AST_DMEM_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dmem_busy && stage_valid[4]) |-> (stage_stall[4] && stage_flush[5])); // R6

  AST_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    redir |=> pc == $past(redirect_pc)); // R7

  AST_NO_STALL_AND_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_stall & stage_flush) == 6'h00); // R8

  AST_FLUSH_BEATS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    redir |-> (stage_stall[2:0] == 3'b000 && stage_flush[2:1] == 2'b11)); // R8

  AST_WB_NEVER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !stage_stall[5]); // R9

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_stall[0] && !redir) |=> $stable(pc)); // R9

  AST_STALL_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    !redir |-> ((stage_stall & (stage_stall + 6'd1)) == 6'h00)); // R5
endmodule

bind pipe_interlock pipe_interlock_chk #(.XLEN(XLEN), .REG_W(REG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stage_valid (stage_valid),
  .id_rs1      (id_rs1),
  .id_rs2      (id_rs2),
  .imem_busy   (imem_busy),
  .dmem_busy   (dmem_busy),
  .mispredict  (mispredict),
  .redirect_pc (redirect_pc),
  .stage_stall (stage_stall),
  .stage_flush (stage_flush),
  .pc          (pc)
);

// File: tb/sim_pipe_interlock.sv
module sim_pipe_interlock;
  localparam logic [31:0] RV = 32'h0000_0100;

  typedef struct packed {
    logic [3:0] req;
    logic [5:0] vld;
    logic [4:0] rs1, rs2, exd;
    logic       exw;
    logic [4:0] memd;
    logic       memw;
    logic [4:0] wbd;
    logic       wbw, ib, db, mp;
    logic [5:0] est, efl;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{4'd4,  6'h3f, 5'd1, 5'd2, 5'd3, 1'b1, 5'd4, 1'b1, 5'd5, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000000, 6'b000000}, // R4
    '{4'd2,  6'h3f, 5'd3, 5'd2, 5'd3, 1'b1, 5'd4, 1'b1, 5'd5, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000111, 6'b001000}, // R2 ex
    '{4'd2,  6'h3f, 5'd1, 5'd4, 5'd3, 1'b1, 5'd4, 1'b1, 5'd5, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000111, 6'b001000}, // R2 mem
    '{4'd2,  6'h3f, 5'd5, 5'd2, 5'd3, 1'b1, 5'd4, 1'b1, 5'd5, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000111, 6'b001000}, // R2 wb
    '{4'd3,  6'h3f, 5'd0, 5'd2, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000000, 6'b000000}, // R3
    '{4'd10, 6'h3f, 5'd3, 5'd2, 5'd3, 1'b0, 5'd4, 1'b1, 5'd5, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000000, 6'b000000}, // R10 no write
    '{4'd10, 6'h37, 5'd3, 5'd2, 5'd3, 1'b1, 5'd4, 1'b1, 5'd5, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000000, 6'b000000}, // R10 ex invalid
    '{4'd10, 6'h3b, 5'd3, 5'd4, 5'd3, 1'b1, 5'd4, 1'b1, 5'd5, 1'b1, 1'b0, 1'b0, 1'b0, 6'b000000, 6'b000000}, // R10 id invalid
    '{4'd5,  6'h3f, 5'd1, 5'd2, 5'd3, 1'b1, 5'd4, 1'b1, 5'd5, 1'b1, 1'b1, 1'b0, 1'b0, 6'b000011, 6'b000100}, // R5
    '{4'd5,  6'h3f, 5'd3, 5'd2, 5'd3, 1'b1, 5'd4, 1'b1, 5'd5, 1'b1, 1'b1, 1'b0, 1'b0, 6'b000111, 6'b001000}, // R5 with R2
    '{4'd6,  6'h3f, 5'd1, 5'd2, 5'd3, 1'b1, 5'd4, 1'b1, 5'd5, 1'b1, 1'b0, 1'b1, 1'b0, 6'b011111, 6'b100000}, // R6
    '{4'd6,  6'h3f, 5'd3, 5'd4, 5'd3, 1'b1, 5'd4, 1'b1, 5'd5, 1'b1, 1'b1, 1'b1, 1'b0, 6'b011111, 6'b100000}, // R6 all holds
    '{4'd7,  6'h3f, 5'd1, 5'd2, 5'd3, 1'b1, 5'd4, 1'b1, 5'd5, 1'b1, 1'b0, 1'b0, 1'b1, 6'b000000, 6'b001110}, // R7
    '{4'd8,  6'h3f, 5'd3, 5'd2, 5'd3, 1'b1, 5'd4, 1'b1, 5'd5, 1'b1, 1'b1, 1'b0, 1'b1, 6'b000000, 6'b001110}, // R8 hazard+imem
    '{4'd8,  6'h3f, 5'd1, 5'd2, 5'd3, 1'b1, 5'd4, 1'b1, 5'd5, 1'b1, 1'b0, 1'b1, 1'b1, 6'b011000, 6'b100110}, // R8 dmem
    '{4'd10, 6'h37, 5'd1, 5'd2, 5'd3, 1'b1, 5'd4, 1'b1, 5'd5, 1'b1, 1'b0, 1'b0, 1'b1, 6'b000000, 6'b000000}  // R10 mp ignored
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  stage_valid = '0;
  logic [4:0]  id_rs1 = '0, id_rs2 = '0, ex_rd = '0, mem_rd = '0, wb_rd = '0;
  logic        ex_rd_we = 1'b0, mem_rd_we = 1'b0, wb_rd_we = 1'b0;
  logic        imem_busy = 1'b0, dmem_busy = 1'b0, mispredict = 1'b0;
  logic [31:0] redirect_pc = '0;
  logic [5:0]  stage_stall, stage_flush;
  logic [31:0] pc;

  int checks = 0;
  int errors = 0;
  logic [31:0] p0;

  always #4 clk = ~clk;

  pipe_interlock #(.XLEN(32), .REG_W(5), .RESET_PC(RV)) u0 (
    .clk(clk), .rst_n(rst_n), .stage_valid(stage_valid),
    .id_rs1(id_rs1), .id_rs2(id_rs2),
    .ex_rd(ex_rd), .ex_rd_we(ex_rd_we), .mem_rd(mem_rd), .mem_rd_we(mem_rd_we),
    .wb_rd(wb_rd), .wb_rd_we(wb_rd_we),
    .imem_busy(imem_busy), .dmem_busy(dmem_busy),
    .mispredict(mispredict), .redirect_pc(redirect_pc),
    .stage_stall(stage_stall), .stage_flush(stage_flush), .pc(pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    stage_valid = v.vld; id_rs1 = v.rs1; id_rs2 = v.rs2;
    ex_rd = v.exd; ex_rd_we = v.exw; mem_rd = v.memd; mem_rd_we = v.memw;
    wb_rd = v.wbd; wb_rd_we = v.wbw;
    imem_busy = v.ib; dmem_busy = v.db; mispredict = v.mp;
  endtask

  task automatic quiet();
    stage_valid = 6'h3f; id_rs1 = 5'd1; id_rs2 = 5'd2;
    ex_rd = 5'd3; ex_rd_we = 1'b1; mem_rd = 5'd4; mem_rd_we = 1'b1;
    wb_rd = 5'd5; wb_rd_we = 1'b1;
    imem_busy = 1'b0; dmem_busy = 1'b0; mispredict = 1'b0;
  endtask

  task automatic next_sample();
    @(negedge clk);
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #2;
    chk("R1 flush", {26'd0, stage_flush}, 32'h3f);
    chk("R1 stall", {26'd0, stage_stall}, 32'h0);
    chk("R1 pc", pc, RV);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1 pc after release", pc, RV);
    next_sample();
    chk("R4 pc step 1", pc, RV + 32'd4);
    next_sample();
    chk("R4 pc step 2", pc, RV + 32'd8);

    // table walk: combinational stall/flush vectors
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(TBL[k]);
      #2;
      chk($sformatf("R%0d row %0d stall", TBL[k].req, k), {26'd0, stage_stall}, {26'd0, TBL[k].est});
      chk($sformatf("R%0d row %0d flush", TBL[k].req, k), {26'd0, stage_flush}, {26'd0, TBL[k].efl});
      chk($sformatf("R9 row %0d wb stall", k), {31'd0, stage_stall[5]}, 32'd0);
    end

    // R9: pc held across two hazard cycles
    @(negedge clk);
    quiet();
    id_rs1 = 5'd3;
    #2;
    p0 = pc;
    next_sample();
    chk("R9 pc hold 1", pc, p0);
    next_sample();
    chk("R9 pc hold 2", pc, p0);

    // R7: redirect loads target
    @(negedge clk);
    quiet();
    mispredict = 1'b1;
    redirect_pc = 32'h0000_0200;
    next_sample();
    chk("R7 pc redirect", pc, 32'h0000_0200);

    // R8: redirect wins over a decode hold
    @(negedge clk);
    quiet();
    id_rs1 = 5'd3;
    imem_busy = 1'b1;
    mispredict = 1'b1;
    redirect_pc = 32'h0000_0440;
    next_sample();
    chk("R8 pc redirect over hold", pc, 32'h0000_0440);

    // R10: mispredict with EX invalid just steps
    @(negedge clk);
    quiet();
    stage_valid = 6'h37;
    mispredict = 1'b1;
    redirect_pc = 32'h0000_0800;
    #2;
    p0 = pc;
    next_sample();
    chk("R10 pc ignores mispredict", pc, p0 + 32'd4);

    // R3: x0 destination with x0 sources keeps pc stepping
    @(negedge clk);
    quiet();
    id_rs1 = 5'd0; id_rs2 = 5'd0; ex_rd = 5'd0;
    #2;
    p0 = pc;
    chk("R3 x0 stall", {26'd0, stage_stall}, 32'h0);
    next_sample();
    chk("R3 x0 pc", pc, p0 + 32'd4);

    // R1: reset again mid-run
    @(negedge clk);
    quiet();
    rst_n = 1'b0;
    #2;
    chk("R1 reassert flush", {26'd0, stage_flush}, 32'h3f);
    chk("R1 reassert pc", pc, RV);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule